// File: doc/BRIEF.md
# Variable-Page Fully Associative Translation Buffer

This block translates virtual addresses into physical page frames. It holds a parameterised number of entries, 64 by default. Each entry pairs a 64-bit tag word with a 64-bit translation word. A lookup presents a virtual address, the current context, the privilege level and the access type. Every entry is compared in parallel. One clock later the block returns exactly one of three outcomes: a hit with its physical frame, a protection fault, or a miss.

Each entry carries its own page-size code, so pages of 8 KB, 64 KB, 512 KB and 4 MB can sit side by side in the same buffer. A small write port loads an entry by index. The block keeps a fault status word and a fault address that record protection faults. A clear input resets the status word. When translation is switched off, addresses pass straight through with full permission.

The parameter `DATA_SIDE` selects between two variants. The data-side variant checks write permission. The instruction-side variant does not check it and never records the write bit.

Top module: `vtlb_xlate`

## Requirements
- R1: While reset is asserted and after it is released, `rsp_valid`, `rsp_hit`, `rsp_fault`, `rsp_miss`, `rsp_writable`, `rsp_pfn`, `fault_stat` and `fault_addr` are all zero.
- R2: Translation-word bits 62:61 give the page size: 0 means 8 KB, 1 means 64 KB, 2 means 512 KB and 3 means 4 MB. The virtual address is masked to the page size and compared with tag bits 63:13. The tag's address bits below the page size take part in the compare.
- R3: Tag bits 12:0 hold a context number. An entry matches only when these bits equal `req_ctx`.
- R4: When several entries match, the entry with the lowest index decides the outcome.
- R5: On a hit, `rsp_pfn` holds physical address bits 40:12. Bits above the page offset come from translation-word bits 40:12. Bits inside the page offset come from the virtual address. `rsp_writable` equals translation-word bit 1.
- R6: A matching entry produces a fault in any of these cases:
  - its valid bit 63 is clear;
  - `req_user` is set and privileged bit 2 is set;
  - on the data side only, `req_write` is set and writable bit 1 is clear.
- R7: On a fault, the status word is rewritten. Bit 0 is set. Bit 3 takes the user flag. Bit 2 takes the write flag, on the data side only. Bit 1 is set when the previous status was nonzero and `stat_clr` was not asserted in that cycle. `fault_addr` captures `req_va`. When `stat_clr` is asserted without a fault, the status word becomes zero.
- R8: A lookup that matches no entry reports a miss and leaves the status word and the fault address unchanged.
- R9: With `xl_enable` low, a lookup hits with `rsp_writable` set and `rsp_pfn` equal to `req_va[40:12]`.
- R10: The response appears on the clock edge that follows the request. A valid response raises exactly one of hit, fault and miss. `rsp_pfn` and `rsp_writable` are zero unless the response is a hit. With no request, all response outputs are zero.
- R11: A write through the load port takes effect at its clock edge. A lookup in the same cycle still sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xl_enable | input | 1 | Translation enable; low selects pass-through |
| wr_en | input | 1 | Load-port write strobe |
| wr_idx | input | $clog2(ENTRIES) | Entry index to load |
| wr_tag | input | 64 | Tag word to load |
| wr_tte | input | 64 | Translation word to load |
| req_valid | input | 1 | Lookup request |
| req_va | input | 64 | Virtual address |
| req_ctx | input | 13 | Current context |
| req_user | input | 1 | Access comes from user mode |
| req_write | input | 1 | Access is a write |
| stat_clr | input | 1 | Clear the fault status word |
| rsp_valid | output | 1 | Response valid |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_fault | output | 1 | Protection fault |
| rsp_miss | output | 1 | No entry matched |
| rsp_writable | output | 1 | Page may be written |
| rsp_pfn | output | 29 | Physical address bits 40:12 |
| fault_stat | output | 4 | Fault status word |
| fault_addr | output | 64 | Address of the last fault |

## Verification
Three situations are hard to reach from the ports alone:
- two entries that match the same address at once;
- an invalid entry that still matches, which turns a would-be miss into a fault;
- a second fault that lands before the status word has been cleared.

The stimulus reaches them with directed loads: two entries with identical tags at indices 10 and 11, an invalid entry with a live tag, and back-to-back faulting lookups with and without `stat_clr`. A random phase then mixes loads, lookups, clears and enable toggles against the bench model. It also overwrites entries while lookups are in flight.

// File: rtl/vtlb_pkg.sv
`timescale 1ns/1ps
package vtlb_pkg;
   localparam int VA_W   = 64;
   localparam int CTX_W  = 13;
   localparam int VPN_W  = VA_W - CTX_W;
   localparam int FRM_LO = 12;
   localparam int FRM_HI = 40;
   localparam int FRM_W  = FRM_HI - FRM_LO + 1;
   localparam int FSR_W  = 4;

   // compressed translation fields kept per entry
   typedef struct packed {
      logic             valid;
      logic [1:0]       size;
      logic [FRM_W-1:0] frame;
      logic             priv;
      logic             wr;
   } tte_fld_t;

   // mask over tag bits 63:13 for a page-size code
   function automatic logic [VPN_W-1:0] vpn_mask(input logic [1:0] sz);
      case (sz)
         2'd0:    vpn_mask = '1;
         2'd1:    vpn_mask = {{(VPN_W-3){1'b1}}, 3'b0};
         2'd2:    vpn_mask = {{(VPN_W-6){1'b1}}, 6'b0};
         default: vpn_mask = {{(VPN_W-9){1'b1}}, 9'b0};
      endcase
   endfunction

   // mask over physical bits 40:12 that come from the entry
   function automatic logic [FRM_W-1:0] frame_mask(input logic [1:0] sz);
      case (sz)
         2'd0:    frame_mask = {{(FRM_W-1){1'b1}}, 1'b0};
         2'd1:    frame_mask = {{(FRM_W-4){1'b1}}, 4'b0};
         2'd2:    frame_mask = {{(FRM_W-7){1'b1}}, 7'b0};
         default: frame_mask = {{(FRM_W-10){1'b1}}, 10'b0};
      endcase
   endfunction
endpackage

// File: rtl/vtlb_store.sv
`timescale 1ns/1ps
module vtlb_store #(
   parameter int ENTRIES = 64,
   parameter int IDX_W   = $clog2(ENTRIES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [IDX_W-1:0]     wr_idx,
   input  logic [63:0]          wr_tag,
   input  logic [63:0]          wr_tte,
   output logic [63:0]          ent_tag [ENTRIES],
   output vtlb_pkg::tte_fld_t   ent_tte [ENTRIES]
);
   import vtlb_pkg::*;

   tte_fld_t wr_fld;
   logic     unused_tte_bits;

   assign wr_fld.valid = wr_tte[63];
   assign wr_fld.size  = wr_tte[62:61];
   assign wr_fld.frame = wr_tte[FRM_HI:FRM_LO];
   assign wr_fld.priv  = wr_tte[2];
   assign wr_fld.wr    = wr_tte[1];
   assign unused_tte_bits = ^{wr_tte[60:41], wr_tte[11:3], wr_tte[0]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) begin
            ent_tag[i] <= '0;
            ent_tte[i] <= '0;
         end
      end else if (wr_en) begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (wr_idx == IDX_W'(i)) begin
               ent_tag[i] <= wr_tag;
               ent_tte[i] <= wr_fld;
            end
         end
      end
   end
endmodule

// File: rtl/vtlb_match.sv
`timescale 1ns/1ps
module vtlb_match #(
   parameter int ENTRIES = 64
) (
   input  logic [vtlb_pkg::VPN_W-1:0] vpn,
   input  logic [vtlb_pkg::CTX_W-1:0] ctx,
   input  logic [63:0]                ent_tag  [ENTRIES],
   input  logic [1:0]                 ent_size [ENTRIES],
   output logic [ENTRIES-1:0]         hit_vec
);
   import vtlb_pkg::*;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      logic ctx_eq;
      logic page_eq;
      assign ctx_eq  = (ent_tag[g][CTX_W-1:0] == ctx);
      assign page_eq = ((vpn & vpn_mask(ent_size[g])) == ent_tag[g][63:CTX_W]);
      assign hit_vec[g] = ctx_eq & page_eq;
   end
endmodule

// File: rtl/vtlb_pick.sv
`timescale 1ns/1ps
module vtlb_pick #(
   parameter int ENTRIES = 64
) (
   input  logic [ENTRIES-1:0]  hit_vec,
   input  vtlb_pkg::tte_fld_t  ent_tte [ENTRIES],
   output logic                any_hit,
   output vtlb_pkg::tte_fld_t  sel_tte
);
   always_comb begin
      any_hit = |hit_vec;
      sel_tte = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (hit_vec[i]) sel_tte = ent_tte[i];
      end
   end
endmodule

// File: rtl/vtlb_fstat.sv
`timescale 1ns/1ps
module vtlb_fstat #(
   parameter int DATA_SIDE = 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       log_en,
   input  logic                       clr,
   input  logic                       is_user,
   input  logic                       is_write,
   input  logic [63:0]                va,
   output logic [vtlb_pkg::FSR_W-1:0] fsr,
   output logic [63:0]                far
);
   logic wbit;

   if (DATA_SIDE != 0) begin : g_data
      assign wbit = is_write;
   end else begin : g_code
      logic unused_write;
      assign unused_write = is_write;
      assign wbit = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fsr <= '0;
         far <= '0;
      end else if (log_en) begin
         fsr <= {is_user, wbit, (fsr != '0) && !clr, 1'b1};
         far <= va;
      end else if (clr) begin
         fsr <= '0;
      end
   end
endmodule

// File: rtl/vtlb_xlate.sv
`timescale 1ns/1ps
module vtlb_xlate #(
   parameter int ENTRIES   = 64,
   parameter int DATA_SIDE = 1,
   localparam int IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               xl_enable,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [63:0]        wr_tag,
   input  logic [63:0]        wr_tte,
   input  logic               req_valid,
   input  logic [63:0]        req_va,
   input  logic [12:0]        req_ctx,
   input  logic               req_user,
   input  logic               req_write,
   input  logic               stat_clr,
   output logic               rsp_valid,
   output logic               rsp_hit,
   output logic               rsp_fault,
   output logic               rsp_miss,
   output logic               rsp_writable,
   output logic [28:0]        rsp_pfn,
   output logic [3:0]         fault_stat,
   output logic [63:0]        fault_addr
);
   import vtlb_pkg::*;

   if (ENTRIES < 2 || ENTRIES > 256) begin : g_bad_entries
      $error("vtlb_xlate: ENTRIES must lie in 2..256");
   end
   if (DATA_SIDE < 0 || DATA_SIDE > 1) begin : g_bad_side
      $error("vtlb_xlate: DATA_SIDE must be 0 or 1");
   end
   if (FRM_W != 29 || CTX_W != 13 || FSR_W != 4) begin : g_bad_pkg
      $error("vtlb_xlate: package widths disagree with port widths");
   end

   logic [63:0]        ent_tag  [ENTRIES];
   tte_fld_t           ent_tte  [ENTRIES];
   logic [1:0]         ent_size [ENTRIES];
   logic [ENTRIES-1:0] hit_vec;
   logic               any_hit;
   tte_fld_t           sel;
   logic               wr_deny;
   logic               flt;
   logic               log_en;
   logic [FRM_W-1:0]   fmask;
   logic               n_hit, n_fault, n_miss, n_wr;
   logic [FRM_W-1:0]   n_pfn;

   vtlb_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_tag  (wr_tag),
      .wr_tte  (wr_tte),
      .ent_tag (ent_tag),
      .ent_tte (ent_tte)
   );

   always_comb begin
      for (int i = 0; i < ENTRIES; i++) ent_size[i] = ent_tte[i].size;
   end

   vtlb_match #(.ENTRIES(ENTRIES)) u_match (
      .vpn      (req_va[63:CTX_W]),
      .ctx      (req_ctx),
      .ent_tag  (ent_tag),
      .ent_size (ent_size),
      .hit_vec  (hit_vec)
   );

   vtlb_pick #(.ENTRIES(ENTRIES)) u_pick (
      .hit_vec (hit_vec),
      .ent_tte (ent_tte),
      .any_hit (any_hit),
      .sel_tte (sel)
   );

   if (DATA_SIDE != 0) begin : g_wchk
      assign wr_deny = req_write & ~sel.wr;
   end else begin : g_nowchk
      assign wr_deny = 1'b0;
   end

   assign flt    = ~sel.valid | (req_user & sel.priv) | wr_deny;
   assign log_en = req_valid & xl_enable & any_hit & flt;
   assign fmask  = frame_mask(sel.size);

   always_comb begin
      n_hit   = 1'b0;
      n_fault = 1'b0;
      n_miss  = 1'b0;
      n_wr    = 1'b0;
      n_pfn   = '0;
      if (req_valid) begin
         if (!xl_enable) begin
            n_hit = 1'b1;
            n_wr  = 1'b1;
            n_pfn = req_va[FRM_HI:FRM_LO];
         end else if (!any_hit) begin
            n_miss = 1'b1;
         end else if (flt) begin
            n_fault = 1'b1;
         end else begin
            n_hit = 1'b1;
            n_wr  = sel.wr;
            n_pfn = (sel.frame & fmask) | (req_va[FRM_HI:FRM_LO] & ~fmask);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_hit      <= 1'b0;
         rsp_fault    <= 1'b0;
         rsp_miss     <= 1'b0;
         rsp_writable <= 1'b0;
         rsp_pfn      <= '0;
      end else begin
         rsp_valid    <= req_valid;
         rsp_hit      <= n_hit;
         rsp_fault    <= n_fault;
         rsp_miss     <= n_miss;
         rsp_writable <= n_wr;
         rsp_pfn      <= n_pfn;
      end
   end

   vtlb_fstat #(.DATA_SIDE(DATA_SIDE)) u_fstat (
      .clk      (clk),
      .rst_n    (rst_n),
      .log_en   (log_en),
      .clr      (stat_clr),
      .is_user  (req_user),
      .is_write (req_write),
      .va       (req_va),
      .fsr      (fault_stat),
      .far      (fault_addr)
   );
endmodule

// File: rtl/vtlb_xlate_chk.sv
`timescale 1ns/1ps
module vtlb_xlate_chk #(
   parameter int DATA_SIDE = 1
) (
   input logic        clk,
   input logic        rst_n,
   input logic        xl_enable,
   input logic        req_valid,
   input logic [63:0] req_va,
   input logic        req_write,
   input logic        stat_clr,
   input logic        rsp_valid,
   input logic        rsp_hit,
   input logic        rsp_fault,
   input logic        rsp_miss,
   input logic        rsp_writable,
   input logic [28:0] rsp_pfn,
   input logic [3:0]  fault_stat,
   input logic [63:0] fault_addr
);
   assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $countones({rsp_hit, rsp_fault, rsp_miss}) == 1);

   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> !(rsp_hit || rsp_fault || rsp_miss || rsp_writable));

   assert_passthru_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !xl_enable) |=> (rsp_hit && rsp_writable && rsp_pfn == $past(req_va[40:12])));

   assert_fault_logged_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault |-> (fault_stat[0] && fault_addr == $past(req_va)));

   assert_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_fault && $past(fault_stat) != 4'd0 && !$past(stat_clr)) |-> fault_stat[1]);

   assert_miss_keeps_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_miss && !$past(stat_clr)) |-> (fault_stat == $past(fault_stat) && $stable(fault_addr)));

   assert_write_needs_perm_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (DATA_SIDE != 0 && rsp_hit && $past(req_write)) |-> rsp_writable);
endmodule

bind vtlb_xlate vtlb_xlate_chk #(.DATA_SIDE(DATA_SIDE)) i_vtlb_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .xl_enable    (xl_enable),
   .req_valid    (req_valid),
   .req_va       (req_va),
   .req_write    (req_write),
   .stat_clr     (stat_clr),
   .rsp_valid    (rsp_valid),
   .rsp_hit      (rsp_hit),
   .rsp_fault    (rsp_fault),
   .rsp_miss     (rsp_miss),
   .rsp_writable (rsp_writable),
   .rsp_pfn      (rsp_pfn),
   .fault_stat   (fault_stat),
   .fault_addr   (fault_addr)
);

// File: tb/test_vtlb_xlate.sv
`timescale 1ns/1ps
module test_vtlb_xlate;
   localparam int NE = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        xl_enable = 1'b0;
   logic        wr_en = 1'b0;
   logic [5:0]  wr_idx = '0;
   logic [63:0] wr_tag = '0;
   logic [63:0] wr_tte = '0;
   logic        req_valid = 1'b0;
   logic [63:0] req_va = '0;
   logic [12:0] req_ctx = '0;
   logic        req_user = 1'b0;
   logic        req_write = 1'b0;
   logic        stat_clr = 1'b0;
   logic        rsp_valid, rsp_hit, rsp_fault, rsp_miss, rsp_writable;
   logic [28:0] rsp_pfn;
   logic [3:0]  fault_stat;
   logic [63:0] fault_addr;

   always #2 clk = ~clk;

   vtlb_xlate #(.ENTRIES(NE), .DATA_SIDE(1)) i_vtlb_xlate (
      .clk(clk), .rst_n(rst_n), .xl_enable(xl_enable),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_tte(wr_tte),
      .req_valid(req_valid), .req_va(req_va), .req_ctx(req_ctx),
      .req_user(req_user), .req_write(req_write), .stat_clr(stat_clr),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
      .rsp_miss(rsp_miss), .rsp_writable(rsp_writable), .rsp_pfn(rsp_pfn),
      .fault_stat(fault_stat), .fault_addr(fault_addr)
   );

   // reference model state
   logic [63:0] m_tag [NE];
   logic [63:0] m_tte [NE];
   logic [3:0]  m_fsr;
   logic [63:0] m_far;
   logic        e_valid, e_hit, e_fault, e_miss, e_wr;
   logic [28:0] e_pfn;
   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   function automatic logic [63:0] tag_of(input logic [63:0] va, input logic [12:0] ctx);
      return {va[63:13], ctx};
   endfunction

   function automatic logic [63:0] tte_of(input bit v, input logic [1:0] sz,
                                          input logic [63:0] pa, input bit priv, input bit wr);
      return {v, sz, 20'b0, pa[40:12], 9'b0, priv, wr, 1'b0};
   endfunction

   task automatic cycle(input string tag, input bit en, input bit req,
                        input logic [63:0] va, input logic [12:0] ctx,
                        input bit user, input bit wr, input bit clr,
                        input bit wen, input int widx,
                        input logic [63:0] wtag, input logic [63:0] wtte);
      logic [63:0] low, full;
      bit found, flt;
      int k;
      xl_enable = en; req_valid = req; req_va = va; req_ctx = ctx;
      req_user = user; req_write = wr; stat_clr = clr;
      wr_en = wen; wr_idx = 6'(widx); wr_tag = wtag; wr_tte = wtte;
      // expected outcome from model
      e_valid = req; e_hit = 0; e_fault = 0; e_miss = 0; e_wr = 0; e_pfn = '0;
      found = 0; flt = 0; k = 0;
      if (req && !en) begin
         e_hit = 1; e_wr = 1; e_pfn = va[40:12];
      end else if (req) begin
         for (int i = 0; i < NE; i++) begin
            low = (64'd1 << (13 + 3 * int'(m_tte[i][62:61]))) - 64'd1;
            if (!found && m_tag[i][12:0] == ctx &&
                (va & ~low) == {m_tag[i][63:13], 13'b0}) begin
               found = 1; k = i;
            end
         end
         if (!found) e_miss = 1;
         else begin
            flt = !m_tte[k][63] || (user && m_tte[k][2]) || (wr && !m_tte[k][1]);
            if (flt) e_fault = 1;
            else begin
               low  = (64'd1 << (13 + 3 * int'(m_tte[k][62:61]))) - 64'd1;
               full = (m_tte[k] & ~low) | (va & low);
               e_hit = 1; e_wr = m_tte[k][1]; e_pfn = full[40:12];
            end
         end
      end
      if (e_fault) begin
         m_fsr = {user, wr, (m_fsr != 4'd0) && !clr, 1'b1};
         m_far = va;
      end else if (clr) m_fsr = 4'd0;
      if (wen) begin m_tag[widx] = wtag; m_tte[widx] = wtte; end
      @(posedge clk);
      @(negedge clk);
      checks++;
      if ({rsp_valid, rsp_hit, rsp_fault, rsp_miss, rsp_writable, rsp_pfn, fault_stat, fault_addr} !==
          {e_valid, e_hit, e_fault, e_miss, e_wr, e_pfn, m_fsr, m_far}) begin
         fails++;
         $display("FAIL %s va=%h actual v/h/f/m/w=%b%b%b%b%b pfn=%h fsr=%h far=%h expected v/h/f/m/w=%b%b%b%b%b pfn=%h fsr=%h far=%h",
                  tag, va, rsp_valid, rsp_hit, rsp_fault, rsp_miss, rsp_writable, rsp_pfn, fault_stat, fault_addr,
                  e_valid, e_hit, e_fault, e_miss, e_wr, e_pfn, m_fsr, m_far);
      end
   endtask

   task automatic load(input int idx, input logic [63:0] t, input logic [63:0] e);
      cycle("R11", 1, 0, 0, 0, 0, 0, 0, 1, idx, t, e);
   endtask

   task automatic look(input string tag, input bit en, input logic [63:0] va,
                       input logic [12:0] ctx, input bit user, input bit wr);
      cycle(tag, en, 1, va, ctx, user, wr, 0, 0, 0, 0, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL R10 watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [63:0] pool [8];
      for (int i = 0; i < NE; i++) begin m_tag[i] = '0; m_tte[i] = '0; end
      m_fsr = '0; m_far = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      checks++;
      if ({rsp_valid, rsp_hit, rsp_fault, rsp_miss, rsp_writable, rsp_pfn, fault_stat, fault_addr} !== '0) begin
         fails++;
         $display("FAIL R1 actual=%b%b%b%b%b pfn=%h fsr=%h far=%h expected all zero",
                  rsp_valid, rsp_hit, rsp_fault, rsp_miss, rsp_writable, rsp_pfn, fault_stat, fault_addr);
      end
      rst_n = 1'b1;
      cycle("R1", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

      // R11: loads (one per size code, R2)
      load(0,  tag_of(64'h0000_0000_4000_0000, 13'd5), tte_of(1, 2'd0, 64'h01_2345_6000, 0, 1));
      load(1,  tag_of(64'h0000_0010_0001_0000, 13'd5), tte_of(1, 2'd1, 64'h0A_BCD0_0000, 0, 0));
      load(2,  tag_of(64'hFFFF_8000_0008_0000, 13'd5), tte_of(1, 2'd2, 64'h01_0008_0000, 1, 1));
      load(3,  tag_of(64'h0000_0000_8000_0000, 13'd5), tte_of(1, 2'd3, 64'h01_2340_0000, 0, 1));
      load(4,  tag_of(64'h0000_0000_5000_0000, 13'd5), tte_of(0, 2'd0, 64'h00_1111_0000, 0, 1));
      load(10, tag_of(64'h0000_0000_6000_0000, 13'd5), tte_of(1, 2'd0, 64'h02_0000_0000, 0, 1));
      load(11, tag_of(64'h0000_0000_6000_0000, 13'd5), tte_of(1, 2'd0, 64'h03_0000_0000, 0, 1));

      // R2 / R5: size masks and frame composition
      look("R2", 1, 64'h0000_0000_4000_1ABC, 13'd5, 0, 0);
      look("R2", 1, 64'h0000_0000_4000_2000, 13'd5, 0, 0);
      look("R5", 1, 64'h0000_0010_0001_F123, 13'd5, 0, 0);
      look("R2", 1, 64'h0000_0010_0002_0000, 13'd5, 0, 0);
      look("R5", 1, 64'hFFFF_8000_000F_FFF0, 13'd5, 0, 1);
      look("R5", 1, 64'h0000_0000_803F_F000, 13'd5, 0, 0);
      look("R2", 1, 64'h0000_0000_8040_0000, 13'd5, 0, 0);
      // R3: context mismatch
      look("R3", 1, 64'h0000_0000_4000_0000, 13'd6, 0, 0);
      // R4: lowest index wins
      look("R4", 1, 64'h0000_0000_6000_0100, 13'd5, 0, 0);
      // R6: fault causes
      look("R6", 1, 64'h0000_0000_5000_0040, 13'd5, 0, 0);
      look("R6", 1, 64'hFFFF_8000_0008_0000, 13'd5, 1, 0);
      cycle("R7", 1, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
      look("R6", 1, 64'h0000_0010_0001_0008, 13'd5, 0, 1);
      look("R6", 1, 64'h0000_0000_4000_0010, 13'd5, 0, 1);
      // R7: status word sequencing
      cycle("R7", 1, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
      look("R7", 1, 64'h0000_0010_0001_0100, 13'd5, 1, 1);
      look("R7", 1, 64'h0000_0000_5000_0000, 13'd5, 1, 0);
      cycle("R7", 1, 1, 64'h0000_0010_0001_0200, 13'd5, 1, 1, 1, 0, 0, 0, 0);
      cycle("R7", 1, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
      // R8: miss leaves status alone
      look("R6", 1, 64'h0000_0000_5000_0000, 13'd5, 0, 0);
      look("R8", 1, 64'h0000_0001_0000_0000, 13'd5, 0, 0);
      // R9: pass-through
      look("R9", 0, 64'h1234_5678_9ABC_DEF0, 13'd0, 1, 1);
      // R10: idle cycle
      cycle("R10", 1, 0, 64'h0000_0000_4000_0000, 13'd5, 0, 0, 0, 0, 0, 0, 0);
      // R11: same-cycle load and lookup sees old contents
      cycle("R11", 1, 1, 64'h0000_0000_7000_0000, 13'd5, 0, 0, 0, 1, 20,
            tag_of(64'h0000_0000_7000_0000, 13'd5), tte_of(1, 2'd0, 64'h04_0000_0000, 0, 0));
      look("R11", 1, 64'h0000_0000_7000_0000, 13'd5, 0, 0);

      // R10: random mix against the model
      pool[0] = 64'h0000_0000_4000_0000; pool[1] = 64'h0000_0010_0001_0000;
      pool[2] = 64'hFFFF_8000_0008_0000; pool[3] = 64'h0000_0000_8000_0000;
      pool[4] = 64'h0000_0000_5000_0000; pool[5] = 64'h0000_0000_6000_0000;
      pool[6] = 64'h0000_0000_7000_0000; pool[7] = 64'h0000_0000_8020_0000;
      for (int n = 0; n < 400; n++) begin
         logic [63:0] va, pa;
         bit w;
         va = pool[$urandom % 8] | 64'($urandom % 32'h40000);
         pa = {23'b0, 41'($urandom) << 12};
         w  = ($urandom % 10) == 0;
         cycle("R10", ($urandom % 8) != 0, ($urandom % 4) != 0, va,
               13'd5 + 13'($urandom % 2), 1'($urandom), 1'($urandom),
               ($urandom % 16) == 0, w, int'($urandom % NE),
               tag_of(pool[$urandom % 8], 13'd5 + 13'($urandom % 2)),
               tte_of(1'(($urandom % 5) != 0), 2'($urandom), pa, 1'($urandom), 1'($urandom)));
      end

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule